// File: doc/BRIEF.md
# I2C Register Bank Slave

This block is a slave-only I2C control port for standard-mode traffic. It sits on an open-drain bus. It never drives SCL. It pulls SDA low only to acknowledge or to send a zero bit. Behind the port is a small bank of byte-wide configuration registers, reached through a byte pointer that advances by itself. The top entry of the address map is a fixed identification byte that cannot be written.

A host writes by sending the slave address with the write bit, then one pointer byte, then any number of data bytes. A host reads by first loading the pointer the same way, then issuing a repeated start with the read bit set. Bytes then stream out from the pointer position, one register per byte. The SCL and SDA inputs pass through a multi-flop synchronizer on the system clock. Start and stop conditions are taken as SDA edges while SCL is high. The writable registers are presented to the rest of the chip as one flat bus.

Top module: `i2c_regbank_slave`

## Requirements
- R1: After reset, SDA is released (sda_oe low). Writable register k holds 0x40+k, except register 5, which holds 0x9D.
- R2: An address byte whose upper seven bits equal SLV_ADDR (default 0x38) is acknowledged by pulling SDA low during the ninth clock. Bit 0 is 1 for read and 0 for write. Any other address, including the general-call value 0x00, gets no acknowledge, and SDA stays released until the next start.
- R3: The first byte after a write address loads the pointer. A value above 0x1B loads 0.
- R4: Each later write byte is stored in the register the pointer selects and is acknowledged. The pointer then advances by one.
- R5: When the pointer advances from 0x1B, the last address, it becomes 0. This applies to both writes and reads.
- R6: Address 0x1B always reads 0x12. A write to it is acknowledged, changes nothing, and still advances the pointer.
- R7: After a read address, the slave sends the register at the pointer, MSB first, and advances the pointer after each byte. SDA changes only while SCL is low.
- R8: A master acknowledge requests the next byte. A master not-acknowledge ends the read, and the slave leaves SDA released until the next start.
- R9: A start or stop condition resets the byte and bit state, even in the middle of a byte. The pointer keeps its value across stops and starts, so a read may begin without a new pointer load.
- R10: The cfg_bus port carries writable register k on bits [8k+7:8k], for k from 0 to 26.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock used to oversample the bus |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Sensed level of the SCL line |
| sda_i | input | 1 | Sensed level of the SDA line |
| sda_oe | output | 1 | When high, the pad pulls SDA low |
| cfg_bus | output | 216 | Contents of the writable registers, register k at bits [8k+7:8k] |

## Verification
Two situations are hard to reach from the pins. The first is a pointer that steps from the identification address back to 0 in the middle of a burst. The bench reaches it by starting a write burst at 0x1A so that it crosses 0x1B, then reading across the same boundary after a repeated start. The second is a transfer cut short partway through a byte. The bench reaches it by clocking a few loose bits and then issuing a new start. The pointer-only paths are also exercised: a read with no pointer load after a stop, and a pointer byte beyond the map.

// File: rtl/i2c_rb_pkg.sv
package i2c_rb_pkg;

  typedef enum logic [2:0] {
    S_IDLE,
    S_ADDR,
    S_ACK_ADDR,
    S_WRITE,
    S_ACK_WRITE,
    S_READ,
    S_ACK_READ
  } fsm_t;

  // reset content of writable register idx
  function automatic logic [7:0] reg_default(input int unsigned idx,
                                             input int unsigned sat_idx,
                                             input logic [7:0] sat_val);
    if (idx == sat_idx) return sat_val;
    return 8'(8'h40 + idx);
  endfunction

  // pointer step with wrap after the top entry
  function automatic logic [7:0] ptr_next(input logic [7:0] p, input logic [7:0] last);
    return (p == last) ? 8'h00 : p + 8'h01;
  endfunction

  // pointer load clipped to the map
  function automatic logic [7:0] ptr_clip(input logic [7:0] v, input logic [7:0] last);
    return (v > last) ? 8'h00 : v;
  endfunction

endpackage

// File: rtl/i2c_rb_sync.sv
module i2c_rb_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_s,
  output logic start_ev,
  output logic stop_ev,
  output logic rise_ev,
  output logic fall_ev
);
  logic [STAGES-1:0] scl_ff, sda_ff;
  logic scl_d, sda_d, scl_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_ff <= '1;
      sda_ff <= '1;
      scl_d  <= 1'b1;
      sda_d  <= 1'b1;
    end else begin
      scl_ff <= {scl_ff[STAGES-2:0], scl_i};
      sda_ff <= {sda_ff[STAGES-2:0], sda_i};
      scl_d  <= scl_ff[STAGES-1];
      sda_d  <= sda_ff[STAGES-1];
    end
  end

  assign scl_s    = scl_ff[STAGES-1];
  assign sda_s    = sda_ff[STAGES-1];
  assign start_ev = scl_s & scl_d & sda_d & ~sda_s;
  assign stop_ev  = scl_s & scl_d & ~sda_d & sda_s;
  assign rise_ev  = scl_s & ~scl_d;
  assign fall_ev  = ~scl_s & scl_d;
endmodule

// File: rtl/i2c_rb_engine.sv
module i2c_rb_engine
  import i2c_rb_pkg::*;
#(
  parameter logic [6:0] SLV_ADDR = 7'h38
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sda_s,
  input  logic       start_ev,
  input  logic       stop_ev,
  input  logic       rise_ev,
  input  logic       fall_ev,
  input  logic [7:0] rd_byte,
  output logic       sda_oe,
  output logic       ptr_load,
  output logic       wr_en,
  output logic       rd_take,
  output logic       addr_done,
  output logic       fsm_idle,
  output logic [7:0] data_byte
);
  fsm_t       state;
  logic [3:0] bitcnt;
  logic [7:0] shreg;
  logic       rw, got_ptr, nack;
  logic       addr_match, byte_done_w;

  assign addr_match  = (shreg[7:1] == SLV_ADDR) && (shreg[7:1] != 7'h00);
  assign addr_done   = (state == S_ADDR) && fall_ev && (bitcnt == 4'd8);
  assign byte_done_w = (state == S_WRITE) && fall_ev && (bitcnt == 4'd8);
  assign ptr_load    = byte_done_w && !got_ptr;
  assign wr_en       = byte_done_w && got_ptr;
  assign rd_take     = fall_ev && (((state == S_ACK_ADDR) && rw) ||
                                   ((state == S_ACK_READ) && !nack));
  assign fsm_idle    = (state == S_IDLE);
  assign data_byte   = shreg;
  assign sda_oe      = (state == S_ACK_ADDR) || (state == S_ACK_WRITE) ||
                       ((state == S_READ) && !shreg[7]);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= S_IDLE;
      bitcnt  <= '0;
      shreg   <= '0;
      rw      <= 1'b0;
      got_ptr <= 1'b0;
      nack    <= 1'b0;
    end else if (start_ev) begin
      state   <= S_ADDR;
      bitcnt  <= '0;
      got_ptr <= 1'b0;
    end else if (stop_ev) begin
      state   <= S_IDLE;
      bitcnt  <= '0;
      got_ptr <= 1'b0;
    end else begin
      unique case (state)
        S_ADDR, S_WRITE: begin
          if (rise_ev && bitcnt != 4'd8) begin
            shreg  <= {shreg[6:0], sda_s};
            bitcnt <= bitcnt + 4'd1;
          end else if (addr_done) begin
            if (addr_match) begin
              state <= S_ACK_ADDR;
              rw    <= shreg[0];
            end else begin
              state <= S_IDLE;
            end
          end else if (byte_done_w) begin
            state   <= S_ACK_WRITE;
            got_ptr <= 1'b1;
          end
        end
        S_ACK_ADDR: begin
          if (fall_ev) begin
            bitcnt <= '0;
            if (rw) begin
              state <= S_READ;
              shreg <= rd_byte;
            end else begin
              state <= S_WRITE;
            end
          end
        end
        S_ACK_WRITE: begin
          if (fall_ev) begin
            state  <= S_WRITE;
            bitcnt <= '0;
          end
        end
        S_READ: begin
          if (fall_ev) begin
            if (bitcnt == 4'd7) begin
              state <= S_ACK_READ;
            end else begin
              shreg  <= {shreg[6:0], 1'b0};
              bitcnt <= bitcnt + 4'd1;
            end
          end
        end
        S_ACK_READ: begin
          if (rise_ev) nack <= sda_s;
          if (fall_ev) begin
            bitcnt <= '0;
            if (nack) begin
              state <= S_IDLE;
            end else begin
              state <= S_READ;
              shreg <= rd_byte;
            end
          end
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/i2c_rb_regfile.sv
module i2c_rb_regfile
  import i2c_rb_pkg::*;
#(
  parameter int         NREG    = 28,
  parameter logic [7:0] ID_VAL  = 8'h12,
  parameter int         SAT_IDX = 5,
  parameter logic [7:0] SAT_VAL = 8'h9D
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   ptr_load,
  input  logic                   wr_en,
  input  logic                   rd_take,
  input  logic [7:0]             din,
  output logic [7:0]             rd_byte,
  output logic [7:0]             ptr_q,
  output logic [(NREG-1)*8-1:0]  cfg_bus
);
  localparam int         PW   = $clog2(NREG);
  localparam logic [7:0] LAST = 8'(NREG - 1);

  logic [NREG*8-1:0] bank;

  generate
    for (genvar k = 0; k < NREG; k++) begin : g_reg
      if (k == NREG - 1) begin : g_id
        assign bank[8*k +: 8] = ID_VAL;
      end else begin : g_rw
        logic [7:0] q;
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n)
            q <= reg_default(k, SAT_IDX, SAT_VAL);
          else if (wr_en && ptr_q == 8'(k))
            q <= din;
        end
        assign bank[8*k +: 8] = q;
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                ptr_q <= 8'h00;
    else if (ptr_load)         ptr_q <= ptr_clip(din, LAST);
    else if (wr_en || rd_take) ptr_q <= ptr_next(ptr_q, LAST);
  end

  assign rd_byte = bank[{ptr_q[PW-1:0], 3'b000} +: 8];
  assign cfg_bus = bank[(NREG-1)*8-1:0];
endmodule

// File: rtl/i2c_regbank_slave.sv
module i2c_regbank_slave #(
  parameter logic [6:0] SLV_ADDR    = 7'h38,
  parameter int         NREG        = 28,
  parameter logic [7:0] ID_VAL      = 8'h12,
  parameter int         SAT_IDX     = 5,
  parameter logic [7:0] SAT_VAL     = 8'h9D,
  parameter int         SYNC_STAGES = 2
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  scl_i,
  input  logic                  sda_i,
  output logic                  sda_oe,
  output logic [(NREG-1)*8-1:0] cfg_bus
);
  logic       sda_s, start_ev, stop_ev, rise_ev, fall_ev;
  logic       ptr_load, wr_en, rd_take, addr_done, fsm_idle;
  logic [7:0] data_byte, rd_byte, ptr_q;

  i2c_rb_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
    .sda_s(sda_s), .start_ev(start_ev), .stop_ev(stop_ev),
    .rise_ev(rise_ev), .fall_ev(fall_ev)
  );

  i2c_rb_engine #(.SLV_ADDR(SLV_ADDR)) u_eng (
    .clk(clk), .rst_n(rst_n), .sda_s(sda_s), .start_ev(start_ev),
    .stop_ev(stop_ev), .rise_ev(rise_ev), .fall_ev(fall_ev),
    .rd_byte(rd_byte), .sda_oe(sda_oe), .ptr_load(ptr_load),
    .wr_en(wr_en), .rd_take(rd_take), .addr_done(addr_done),
    .fsm_idle(fsm_idle), .data_byte(data_byte)
  );

  i2c_rb_regfile #(.NREG(NREG), .ID_VAL(ID_VAL), .SAT_IDX(SAT_IDX), .SAT_VAL(SAT_VAL)) u_rf (
    .clk(clk), .rst_n(rst_n), .ptr_load(ptr_load), .wr_en(wr_en),
    .rd_take(rd_take), .din(data_byte), .rd_byte(rd_byte),
    .ptr_q(ptr_q), .cfg_bus(cfg_bus)
  );
endmodule

// File: rtl/i2c_regbank_slave_chk.sv
module i2c_regbank_slave_chk #(
  parameter logic [6:0] SLV_ADDR = 7'h38,
  parameter int         NREG     = 28
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  scl_i,
  input logic                  sda_oe,
  input logic                  fsm_idle,
  input logic                  addr_done,
  input logic [7:0]            data_byte,
  input logic                  wr_en,
  input logic                  rd_take,
  input logic                  ptr_load,
  input logic [7:0]            ptr_q,
  input logic [(NREG-1)*8-1:0] cfg_bus
);
  localparam logic [7:0] LAST = 8'(NREG - 1);

  assert_gencall_nack_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (addr_done && data_byte[7:1] == 7'h00) |=> !sda_oe);

  assert_own_addr_ack_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (addr_done && data_byte[7:1] == SLV_ADDR) |=> sda_oe);

  assert_ptr_in_map_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ptr_load |=> (ptr_q <= LAST));

  assert_ptr_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en || rd_take) |=>
      (ptr_q == (($past(ptr_q) == LAST) ? 8'h00 : $past(ptr_q) + 8'h01)));

  assert_id_write_ignored_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && ptr_q == LAST) |=> $stable(cfg_bus));

  assert_sda_moves_scl_low_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sda_oe) |-> !scl_i);

  assert_idle_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
    fsm_idle |-> !sda_oe);
endmodule

bind i2c_regbank_slave i2c_regbank_slave_chk #(.SLV_ADDR(SLV_ADDR), .NREG(NREG)) u_chk (
  .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_oe(sda_oe),
  .fsm_idle(fsm_idle), .addr_done(addr_done), .data_byte(data_byte),
  .wr_en(wr_en), .rd_take(rd_take), .ptr_load(ptr_load),
  .ptr_q(ptr_q), .cfg_bus(cfg_bus)
);

// File: tb/i2c_regbank_slave_test.sv
module i2c_regbank_slave_test;
  localparam logic [6:0] SLV = 7'h38;
  localparam int NREG = 28;
  localparam int Q = 25;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic m_scl = 1'b1;
  logic m_sda = 1'b1;
  logic done = 1'b0;
  wire  sda_oe;
  wire  sda_line = m_sda & ~sda_oe;
  wire [(NREG-1)*8-1:0] cfg;

  int n_cmp = 0;
  int n_bad = 0;

  always #10 clk = ~clk;

  i2c_regbank_slave #(.SLV_ADDR(SLV), .NREG(NREG)) uut (
    .clk(clk), .rst_n(rst_n), .scl_i(m_scl), .sda_i(sda_line),
    .sda_oe(sda_oe), .cfg_bus(cfg)
  );

  function automatic logic [7:0] dflt(int k);
    return (k == 5) ? 8'h9D : 8'(8'h40 + k);
  endfunction

  task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic qwait();
    repeat (Q) @(negedge clk);
  endtask

  task automatic bus_start();
    m_sda = 1'b1; qwait(); m_scl = 1'b1; qwait(); m_sda = 1'b0; qwait(); m_scl = 1'b0; qwait();
  endtask

  task automatic bus_stop();
    m_sda = 1'b0; qwait(); m_scl = 1'b1; qwait(); m_sda = 1'b1; qwait();
  endtask

  task automatic send_bit(input logic b);
    m_sda = b; qwait(); m_scl = 1'b1; qwait(); qwait(); m_scl = 1'b0; qwait();
  endtask

  task automatic get_bit(output logic b);
    m_sda = 1'b1; qwait(); m_scl = 1'b1; qwait(); b = sda_line; qwait(); m_scl = 1'b0; qwait();
  endtask

  task automatic send_byte(input logic [7:0] d, output logic ackd);
    logic b;
    for (int i = 7; i >= 0; i--) send_bit(d[i]);
    get_bit(b);
    ackd = ~b;
  endtask

  task automatic recv_byte(input logic ack, output logic [7:0] d);
    for (int i = 7; i >= 0; i--) begin
      logic b;
      get_bit(b);
      d[i] = b;
    end
    send_bit(~ack);
  endtask

  task automatic wr_ack(string req, logic [7:0] d, logic exp_ack);
    logic a;
    send_byte(d, a);
    chk(req, {7'b0, a}, {7'b0, exp_ack});
  endtask

  task automatic rd_exp(string req, logic ack, logic [7:0] exp);
    logic [7:0] d;
    recv_byte(ack, d);
    chk(req, d, exp);
  endtask

  function automatic logic [7:0] field(int k);
    return cfg[8*k +: 8];
  endfunction

  task automatic t_reset();
    chk("R1 sda released", {7'b0, sda_oe}, 8'h00);
    for (int k = 0; k < NREG - 1; k++) chk("R1 R10 default", field(k), dflt(k));
  endtask

  task automatic t_write_burst();
    bus_start();
    wr_ack("R2 own write addr ack", {SLV, 1'b0}, 1'b1);
    wr_ack("R3 pointer ack", 8'h03, 1'b1);
    wr_ack("R4 data ack", 8'hA1, 1'b1);
    wr_ack("R4 data ack", 8'hA2, 1'b1);
    wr_ack("R4 data ack", 8'hA3, 1'b1);
    bus_stop(); qwait();
    chk("R4 R10 reg3", field(3), 8'hA1);
    chk("R4 R10 reg4", field(4), 8'hA2);
    chk("R4 R10 reg5", field(5), 8'hA3);
    chk("R4 reg6 untouched", field(6), dflt(6));
  endtask

  task automatic t_read_burst();
    bus_start();
    wr_ack("R2 own write addr ack", {SLV, 1'b0}, 1'b1);
    wr_ack("R3 pointer ack", 8'h03, 1'b1);
    bus_start();
    wr_ack("R7 read addr ack", {SLV, 1'b1}, 1'b1);
    rd_exp("R7 read reg3", 1'b1, 8'hA1);
    rd_exp("R7 read reg4", 1'b1, 8'hA2);
    rd_exp("R8 read reg5 then nack", 1'b0, 8'hA3);
    chk("R8 released after nack", {7'b0, sda_oe}, 8'h00);
    bus_stop();
  endtask

  task automatic t_foreign();
    bus_start();
    wr_ack("R2 foreign addr nack", {7'h21, 1'b0}, 1'b0);
    wr_ack("R2 foreign data nack", 8'h00, 1'b0);
    wr_ack("R2 foreign data nack", 8'hEE, 1'b0);
    bus_stop(); qwait();
    chk("R2 foreign no write", field(0), dflt(0));
  endtask

  task automatic t_gencall();
    bus_start();
    wr_ack("R2 general call nack", 8'h00, 1'b0);
    wr_ack("R2 after general call nack", 8'h05, 1'b0);
    wr_ack("R2 after general call nack", 8'h77, 1'b0);
    bus_stop(); qwait();
    chk("R2 general call no write", field(5), 8'hA3);
  endtask

  task automatic t_wrap();
    bus_start();
    wr_ack("R2 own write addr ack", {SLV, 1'b0}, 1'b1);
    wr_ack("R3 pointer ack", 8'h1A, 1'b1);
    wr_ack("R4 data ack", 8'h55, 1'b1);
    wr_ack("R6 id write acked", 8'h77, 1'b1);
    wr_ack("R5 wrapped write ack", 8'h66, 1'b1);
    bus_stop(); qwait();
    chk("R4 reg26", field(26), 8'h55);
    chk("R5 wrap wrote reg0", field(0), 8'h66);
    chk("R6 reg1 untouched", field(1), dflt(1));
    bus_start();
    wr_ack("R2 own write addr ack", {SLV, 1'b0}, 1'b1);
    wr_ack("R3 pointer ack", 8'h1B, 1'b1);
    bus_start();
    wr_ack("R7 read addr ack", {SLV, 1'b1}, 1'b1);
    rd_exp("R6 id value", 1'b1, 8'h12);
    rd_exp("R5 read wraps to reg0", 1'b0, 8'h66);
    bus_stop();
  endtask

  task automatic t_range();
    bus_start();
    wr_ack("R2 own write addr ack", {SLV, 1'b0}, 1'b1);
    wr_ack("R3 big pointer ack", 8'h40, 1'b1);
    bus_start();
    wr_ack("R7 read addr ack", {SLV, 1'b1}, 1'b1);
    rd_exp("R3 big pointer reads reg0", 1'b0, 8'h66);
    bus_stop();
  endtask

  task automatic t_keep_ptr();
    bus_start();
    wr_ack("R2 own write addr ack", {SLV, 1'b0}, 1'b1);
    wr_ack("R3 pointer ack", 8'h02, 1'b1);
    bus_stop();
    bus_start();
    wr_ack("R9 read addr ack", {SLV, 1'b1}, 1'b1);
    rd_exp("R9 pointer kept across stop", 1'b1, dflt(2));
    rd_exp("R9 next after kept pointer", 1'b0, 8'hA1);
    bus_stop();
  endtask

  task automatic t_abort();
    bus_start();
    send_bit(1'b1); send_bit(1'b0); send_bit(1'b1);
    bus_start();
    wr_ack("R9 addr after abort ack", {SLV, 1'b0}, 1'b1);
    wr_ack("R9 pointer after abort", 8'h07, 1'b1);
    wr_ack("R9 data after abort", 8'h3C, 1'b1);
    bus_stop(); qwait();
    chk("R9 write after abort", field(7), 8'h3C);
    chk("R9 reg8 untouched", field(8), dflt(8));
  endtask

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    t_reset();
    t_write_burst();
    t_read_burst();
    t_foreign();
    t_gencall();
    t_wrap();
    t_range();
    t_keep_ptr();
    t_abort();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule